// File: doc/BRIEF.md
# Configuration Port Unlock and Index Decoder

This block guards the configuration space of a PC-style multi-peripheral I/O device behind a two-port index/data window on the host I/O bus. Host software opens the window by writing a key byte twice in a row to the index port. It then selects a register by writing its number to the index port and reads or writes that register through the data port. A second key byte closes the window again. The index port address is one of two fixed values, chosen by a strap pin that is captured while reset is held. The data port is always the address that follows the index port.

Registers below 0x30 are global. Register 0x07 selects the logical device, numbered 0 to 0x0B. A byte at 0x02 with bit 0 set triggers a soft reset. Registers 0x20 to 0x2F are shared scratch storage. Registers 0x30 to 0x3F form a separate bank for each logical device. Bit 0 of register 0x30 in each bank drives that device's activate output. The I/O strobes are plain single-cycle control pulses with no back-pressure: every strobe is accepted in the cycle it is seen.

Top module: `cfg_port_decoder`

## Requirements
- R1: Two index-port writes of 0x87 in a row unlock configuration mode, and `cfg_unlocked` is high from the cycle after the second write.
- R2: An index-port write of any byte other than 0x87 between the two key writes leaves the block locked and restarts the sequence, so two further 0x87 writes are needed.
- R3: While unlocked, an index-port write of 0xAA relocks the block in the next cycle.
- R4: With `strap_alt` low during reset, the index port is 0x2E and the data port 0x2F. With it high, they are 0x4E and 0x4F. Key writes to the other address have no effect.
- R5: While locked, data-port writes change no register, and reads of either port return 0xFF.
- R6: Read data appears on `io_rdata` in the cycle after the read strobe and holds until the next read. While unlocked, an index-port read returns the last index written.
- R7: Register 0x07 stores the logical device number and reads back the value written.
- R8: Registers 0x30 to 0x3F are held separately for each logical device 0 to 0x0B. With a device number above 0x0B selected, writes to them are dropped and reads return 0x00.
- R9: Bit 0 of register 0x30 of device n drives `dev_active[n]` from the cycle after the write.
- R10: Registers 0x20 to 0x2F are shared by all devices and read back the same value whatever device is selected.
- R11: Writing 0x02 with bit 0 set clears every device bank, so all `dev_active` bits are low two cycles after the write. The logical device number and the shared registers are kept, and register 0x02 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the strap is captured while it is low |
| strap_alt | input | 1 | Strap pin: 0 selects ports 0x2E/0x2F, 1 selects 0x4E/0x4F |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| cfg_unlocked | output | 1 | High while configuration mode is open |
| dev_active | output | 12 | Activate bit of each logical device |

## Verification
A corrupted unlock state shows up at once on `cfg_unlocked`. It also shows on the next read of either port, which returns 0xFF in place of register data or the other way round. A wrong bank selection or a lost soft reset shows on `dev_active` one or two cycles after the triggering write, and on readback of the shared and banked registers under a different device number. A wrong strap capture shows only after a fresh reset, when the key sequence succeeds at the wrong address.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] KEY_ENTER = 8'h87;
  localparam logic [7:0] KEY_EXIT  = 8'hAA;
  localparam logic [7:0] REG_SOFT  = 8'h02;
  localparam logic [7:0] REG_LDN   = 8'h07;
  localparam logic [7:0] GLB_BASE  = 8'h20;
  localparam logic [7:0] BANK_BASE = 8'h30;
  localparam logic [15:0] PORT_MAIN = 16'h002E;
  localparam logic [15:0] PORT_ALT  = 16'h004E;

  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_e;
endpackage

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_idx,
  input  logic [7:0] wdata,
  output logic       unlocked,
  output logic [7:0] index_q
);
  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_idx) begin
      unique case (state_q)
        LK_CLOSED: state_d = (wdata == KEY_ENTER) ? LK_HALF : LK_CLOSED;
        LK_HALF:   state_d = (wdata == KEY_ENTER) ? LK_OPEN : LK_CLOSED;
        LK_OPEN:   state_d = (wdata == KEY_EXIT)  ? LK_CLOSED : LK_OPEN;
        default:   state_d = LK_CLOSED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_CLOSED;
      index_q <= 8'h00;
    end else begin
      state_q <= state_d;
      if (wr_idx && state_q == LK_OPEN && wdata != KEY_EXIT)
        index_q <= wdata;
    end
  end

  assign unlocked = (state_q == LK_OPEN);

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && !$past(unlocked)) |-> ($past(wr_idx) && $past(wdata) == KEY_ENTER)); // R1
  AST_EXIT_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && wr_idx && wdata == KEY_EXIT) |=> !unlocked); // R3
  AST_BAD_KEY_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && wr_idx && wdata != KEY_ENTER) |=> !unlocked); // R2
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_port_pkg::*;
#(
  parameter int GLB_REGS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] index,
  input  logic [7:0] wdata,
  output logic [7:0] ldn_q,
  output logic       soft_rst,
  output logic [7:0] rd_val
);
  localparam int GOFF_W = $clog2(GLB_REGS);

  logic [GLB_REGS-1:0][7:0] scratch_q;
  logic [7:0] grel;
  logic       in_scratch;
  logic       soft_q;

  assign grel       = index - GLB_BASE;
  assign in_scratch = (grel < 8'(GLB_REGS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldn_q     <= 8'h00;
      scratch_q <= '0;
      soft_q    <= 1'b0;
    end else begin
      soft_q <= wr_en && index == REG_SOFT && wdata[0];
      if (wr_en && index == REG_LDN) ldn_q <= wdata;
      if (wr_en && in_scratch) scratch_q[grel[GOFF_W-1:0]] <= wdata;
    end
  end

  always_comb begin
    if (index == REG_LDN)  rd_val = ldn_q;
    else if (in_scratch)   rd_val = scratch_q[grel[GOFF_W-1:0]];
    else                   rd_val = 8'h00;
  end

  assign soft_rst = soft_q;

  AST_SOFT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst); // R11
  AST_LDN_KEPT_ON_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !wr_en) |=> $stable(ldn_q)); // R11
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank #(
  parameter int NUM_DEV   = 12,
  parameter int BANK_REGS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_clr,
  input  logic               wr_en,
  input  logic [7:0]         ldn,
  input  logic [7:0]         off,
  input  logic [7:0]         wdata,
  output logic [7:0]         rd_val,
  output logic [NUM_DEV-1:0] dev_active
);
  localparam int LDN_W = $clog2(NUM_DEV);
  localparam int OFF_W = $clog2(BANK_REGS);

  logic [NUM_DEV-1:0][BANK_REGS-1:0][7:0] rows;
  logic             ldn_ok;
  logic [LDN_W-1:0] sel;
  logic [OFF_W-1:0] ofs;
  logic             off_ok;

  assign ldn_ok = (ldn < 8'(NUM_DEV));
  assign sel    = ldn[LDN_W-1:0];
  assign off_ok = (off < 8'(BANK_REGS));
  assign ofs    = off[OFF_W-1:0];

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    logic [BANK_REGS-1:0][7:0] regs_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q <= '0;
      else if (soft_clr)
        regs_q <= '0;
      else if (wr_en && ldn_ok && off_ok && sel == LDN_W'(g))
        regs_q[ofs] <= wdata;
    end
    assign rows[g]       = regs_q;
    assign dev_active[g] = regs_q[0][0];
  end

  always_comb begin
    if (ldn_ok && off_ok) rd_val = rows[sel][ofs];
    else                  rd_val = 8'h00;
  end

  AST_SOFT_CLEARS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (dev_active == '0)); // R11
  AST_BAD_LDN_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ldn_ok && !soft_clr) |=> $stable(dev_active)); // R8
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfg_port_pkg::*;
#(
  parameter int NUM_DEV   = 12,
  parameter int BANK_REGS = 16,
  parameter int GLB_REGS  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strap_alt,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic [15:0]        io_addr,
  input  logic [7:0]         io_wdata,
  output logic [7:0]         io_rdata,
  output logic               cfg_unlocked,
  output logic [NUM_DEV-1:0] dev_active
);
  logic        strap_q;
  logic [15:0] idx_port, dat_port;
  logic        hit_idx, hit_dat;
  logic        wr_idx, wr_dat;
  logic [7:0]  index_q, ldn_q, glb_rd, bank_rd, bank_off;
  logic        is_global, soft_rst;
  logic [7:0]  rdata_q, rd_mux;

  // Strap sampled only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_alt;
  end

  assign idx_port = strap_q ? PORT_ALT : PORT_MAIN;
  assign dat_port = idx_port + 16'd1;
  assign hit_idx  = (io_addr == idx_port);
  assign hit_dat  = (io_addr == dat_port);
  assign wr_idx   = io_wr && hit_idx;
  assign wr_dat   = io_wr && hit_dat && cfg_unlocked;

  assign is_global = (index_q < BANK_BASE);
  assign bank_off  = index_q - BANK_BASE;

  cfg_unlock_fsm u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_idx   (wr_idx),
    .wdata    (io_wdata),
    .unlocked (cfg_unlocked),
    .index_q  (index_q)
  );

  cfg_global_regs #(.GLB_REGS(GLB_REGS)) u_glb (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_dat && is_global),
    .index    (index_q),
    .wdata    (io_wdata),
    .ldn_q    (ldn_q),
    .soft_rst (soft_rst),
    .rd_val   (glb_rd)
  );

  cfg_dev_bank #(.NUM_DEV(NUM_DEV), .BANK_REGS(BANK_REGS)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_clr   (soft_rst),
    .wr_en      (wr_dat && !is_global),
    .ldn        (ldn_q),
    .off        (bank_off),
    .wdata      (io_wdata),
    .rd_val     (bank_rd),
    .dev_active (dev_active)
  );

  always_comb begin
    if (!cfg_unlocked)   rd_mux = 8'hFF;
    else if (hit_idx)    rd_mux = index_q;
    else if (hit_dat)    rd_mux = is_global ? glb_rd : bank_rd;
    else                 rd_mux = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= 8'hFF;
    else if (io_rd) rdata_q <= rd_mux;
  end

  assign io_rdata = rdata_q;

  AST_READ_LOCKED_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !cfg_unlocked) |=> (io_rdata == 8'hFF)); // R5
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata)); // R6
  AST_LOCKED_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_unlocked && !soft_rst) |=> $stable(dev_active)); // R5
endmodule

// File: tb/cfg_port_decoder_tb.sv
module cfg_port_decoder_tb_top;
  localparam int NDEV = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            strap_alt = 1'b0;
  logic            io_wr = 1'b0;
  logic            io_rd = 1'b0;
  logic [15:0]     io_addr = 16'h0;
  logic [7:0]      io_wdata = 8'h0;
  logic [7:0]      io_rdata;
  logic            cfg_unlocked;
  logic [NDEV-1:0] dev_active;

  int n_checks = 0;
  int n_errors = 0;
  logic [15:0] ip = 16'h2E;

  always #10 clk = ~clk;

  cfg_port_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
    .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cfg_unlocked(cfg_unlocked), .dev_active(dev_active)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0;
    strap_alt = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    strap_alt = ~strap;
    ip = strap ? 16'h4E : 16'h2E;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    io_write(ip, idx);
    io_write(ip + 16'd1, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
    io_write(ip, idx);
    io_read(ip + 16'd1, d);
  endtask

  task automatic unlock();
    io_write(ip, 8'h87);
    io_write(ip, 8'h87);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    check("R5 reset locked", cfg_unlocked, 0);
    check("R9 reset active", dev_active, 0);
    io_read(ip, d);
    check("R5 locked idx read", d, 8'hFF);
    io_read(ip + 16'd1, d);
    check("R5 locked data read", d, 8'hFF);
  endtask

  task automatic t_unlock_exit();
    logic [7:0] d;
    io_write(ip, 8'h87);
    check("R1 one key stays locked", cfg_unlocked, 0);
    io_write(ip, 8'h87);
    check("R1 two keys unlock", cfg_unlocked, 1);
    reg_wr(8'h20, 8'h5A);
    io_write(ip, 8'hAA);
    check("R3 exit relocks", cfg_unlocked, 0);
    io_write(ip + 16'd1, 8'h11);
    unlock();
    reg_rd(8'h20, d);
    check("R5 locked write ignored", d, 8'h5A);
    io_write(ip, 8'hAA);
  endtask

  task automatic t_broken_key();
    io_write(ip, 8'h87);
    io_write(ip, 8'h12);
    io_write(ip, 8'h87);
    check("R2 broken sequence locked", cfg_unlocked, 0);
    io_write(ip, 8'h87);
    check("R2 restarted sequence unlocks", cfg_unlocked, 1);
    io_write(ip, 8'hAA);
  endtask

  task automatic t_banks();
    logic [7:0] d;
    unlock();
    reg_wr(8'h07, 8'h03);
    reg_rd(8'h07, d);
    check("R7 ldn readback", d, 8'h03);
    reg_wr(8'h30, 8'h01);
    check("R9 activate dev3", dev_active, 12'h008);
    reg_wr(8'h31, 8'hA5);
    reg_wr(8'h07, 8'h05);
    reg_wr(8'h31, 8'h3C);
    reg_rd(8'h31, d);
    check("R8 bank dev5", d, 8'h3C);
    reg_wr(8'h07, 8'h03);
    reg_rd(8'h31, d);
    check("R8 bank dev3 separate", d, 8'hA5);
    reg_wr(8'h07, 8'h0F);
    reg_wr(8'h31, 8'h77);
    reg_rd(8'h31, d);
    check("R8 bad ldn reads zero", d, 8'h00);
    reg_wr(8'h07, 8'h05);
    reg_rd(8'h31, d);
    check("R8 bad ldn write dropped", d, 8'h3C);
    reg_wr(8'h07, 8'h0B);
    reg_wr(8'h30, 8'h01);
    check("R9 activate dev11", dev_active, 12'h808);
  endtask

  task automatic t_global();
    logic [7:0] d;
    reg_wr(8'h07, 8'h03);
    reg_wr(8'h25, 8'hC3);
    reg_wr(8'h07, 8'h05);
    reg_rd(8'h25, d);
    check("R10 shared across ldn", d, 8'hC3);
    io_read(ip, d);
    check("R6 index readback", d, 8'h25);
    @(negedge clk);
    check("R6 rdata holds", io_rdata, 8'h25);
  endtask

  task automatic t_soft();
    logic [7:0] d;
    io_write(ip, 8'h02);
    @(negedge clk);
    io_wr = 1'b1; io_addr = ip + 16'd1; io_wdata = 8'h01;
    @(negedge clk);
    io_wr = 1'b0;
    check("R11 not yet cleared", dev_active, 12'h808);
    @(negedge clk);
    check("R11 active cleared", dev_active, 12'h000);
    reg_rd(8'h02, d);
    check("R11 soft reg reads zero", d, 8'h00);
    reg_rd(8'h07, d);
    check("R11 ldn kept", d, 8'h05);
    reg_rd(8'h25, d);
    check("R11 shared kept", d, 8'hC3);
    reg_rd(8'h31, d);
    check("R11 bank cleared", d, 8'h00);
  endtask

  task automatic t_strap();
    logic [7:0] d;
    do_reset(1'b1);
    io_write(16'h2E, 8'h87);
    io_write(16'h2E, 8'h87);
    check("R4 main port ignored", cfg_unlocked, 0);
    unlock();
    check("R4 alt port unlocks", cfg_unlocked, 1);
    reg_wr(8'h07, 8'h09);
    io_write(ip, 8'h07);
    io_read(16'h004F, d);
    check("R4 alt data port", d, 8'h09);
  endtask

  initial begin
    fork
      begin
        do_reset(1'b0);
        t_reset_state();
        t_unlock_exit();
        t_broken_key();
        t_banks();
        t_global();
        t_soft();
        t_strap();
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule